// File: doc/BRIEF.md
# Monitor Channel Receive Handshake Controller

This block is the receiving end of a byte-wide side channel that carries one byte per frame. A frame strobe marks each frame. On every strobe the block samples the incoming byte together with a transmit-valid flag, and it drives a receive-acknowledge flag back to the sender. Both flags are active low: 0 means active and 1 means inactive. The block works out when the sender has offered a fresh byte, stores that byte for the host, and acknowledges it only after the host has read it. It also reports when the sender has closed the message, and it lets the host ask the sender to abort.

The host has four things to work with. A receive-control bit enables the acknowledge flag. A read strobe tells the block that the stored byte has been consumed. The receive data register holds the stored byte. Two single-cycle interrupt pulses report a received byte and the end of a message. The first acknowledge of a message is shown by the acknowledge flag turning active. Every later acknowledge is shown by the flag going inactive for exactly one frame and then active again. Pulling the receive-control bit low holds the acknowledge flag inactive, and when it stays low for two or more frames the sender takes that as an abort request. Extracting the two flags and the byte from the serial frame is done elsewhere.

Top module: `mon_rx_handshake`

## Requirements
- R1: After reset, mr_out is 1 (inactive), rx_data is 0, and both irq_data and irq_end are 0.
- R2: State changes only on clock cycles where frame_stb is 1. mr_out, rx_data and both interrupts are updated on the clock edge that samples that strobe. With frame_stb at 0, any change on mx_in or rx_byte has no effect.
- R3: A fresh byte is detected on a frame where mx_in is 0 and the previous frame's mx_in was 1 (the value before the first frame counts as 1). If no byte is waiting to be read, rx_byte is stored into rx_data and irq_data pulses high for one cycle.
- R4: A frame where mx_in stays 0 after a frame where it was already 0 is a repeat. It stores nothing and raises no interrupt.
- R5: A fresh byte that arrives while the previous byte has not yet been read through host_rd is not stored, and it raises no irq_data.
- R6: With rx_ctrl at 1 and mr_out inactive, a host_rd of a waiting byte makes mr_out 0 at the next frame strobe. This is the first acknowledge.
- R7: With mr_out active, a host_rd of a waiting byte makes mr_out 1 for exactly the next frame and 0 again at the frame after. This is a later acknowledge.
- R8: No acknowledge is given unless host_rd has come while a byte was waiting. A host_rd with nothing waiting has no effect.
- R9: After a fresh byte has been detected, the second consecutive frame with mx_in at 1 pulses irq_end once. Further idle frames raise nothing until the next fresh byte.
- R10: A frame strobe with rx_ctrl at 0 forces mr_out to 1, and mr_out stays 1 on every later frame while rx_ctrl remains 0.
- R11: irq_data and irq_end are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse, once per frame |
| mx_in | input | 1 | Sender's transmit-valid flag, 0 = active |
| rx_byte | input | DATA_W | Byte carried in the current frame |
| rx_ctrl | input | 1 | Host receive-control bit, enables the acknowledge |
| host_rd | input | 1 | Host read strobe for rx_data |
| mr_out | output | 1 | Receive-acknowledge flag, 0 = active |
| rx_data | output | DATA_W | Last stored byte |
| irq_data | output | 1 | Pulse: a byte was stored |
| irq_end | output | 1 | Pulse: end of message |

## Verification
The bench targets five corner cases:

- **Repeated byte with mx_in held active.** A design that treats it as new would raise a second data interrupt and overwrite the register.
- **Fresh byte arriving before the host read.** Latching it would lose an unread byte.
- **Acknowledge shape.** A blip that lasts two frames, or is missing altogether, would stall or confuse the sender. A host read with nothing waiting must not be turned into an acknowledge.
- **End of message.** The bench checks that irq_end fires exactly once after two idle frames, and never while the line sits idle between messages.
- **Receive-control cleared mid-transfer.** mr_out must be held inactive on every frame while the bit stays low.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;

    localparam logic FLAG_ACTIVE = 1'b0;
    localparam logic FLAG_IDLE   = 1'b1;

    typedef enum logic [1:0] {
        ACK_OFF = 2'd0,
        ACK_ON  = 2'd1,
        ACK_GAP = 2'd2
    } ack_state_e;

    typedef struct packed {
        logic fresh;
        logic closing;
    } mx_event_t;

    function automatic logic went_active(input logic now_v, input logic before_v);
        return (now_v == FLAG_ACTIVE) && (before_v == FLAG_IDLE);
    endfunction

    function automatic logic stayed_idle(input logic now_v, input logic before_v);
        return (now_v == FLAG_IDLE) && (before_v == FLAG_IDLE);
    endfunction

endpackage

// File: rtl/mon_rx_mx_track.sv
module mon_rx_mx_track
    import mon_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_stb,
    input  logic      mx_in,
    output mx_event_t ev,
    output logic      irq_end
);

    logic mx_last;
    logic in_msg;

    always_comb begin
        ev.fresh   = frame_stb && went_active(mx_in, mx_last);
        ev.closing = frame_stb && in_msg && stayed_idle(mx_in, mx_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mx_last <= FLAG_IDLE;
            in_msg  <= 1'b0;
            irq_end <= 1'b0;
        end else begin
            irq_end <= ev.closing;
            if (frame_stb) begin
                mx_last <= mx_in;
            end
            if (ev.fresh) begin
                in_msg <= 1'b1;
            end else if (ev.closing) begin
                in_msg <= 1'b0;
            end
        end
    end

    // R9
    end_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        irq_end |-> ($past(frame_stb) && ($past(mx_in) == FLAG_IDLE)));

    // R9
    end_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_end |=> !irq_end);

endmodule

// File: rtl/mon_rx_store.sv
module mon_rx_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fresh,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              host_rd,
    input  logic              ack_take,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq_data,
    output logic              ack_req
);

    logic unread;
    logic rd_ok;
    logic take_in;

    always_comb begin
        rd_ok   = host_rd && unread;
        take_in = fresh && !unread;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            irq_data <= 1'b0;
            unread   <= 1'b0;
            ack_req  <= 1'b0;
        end else begin
            irq_data <= take_in;
            if (take_in) begin
                rx_data <= rx_byte;
                unread  <= 1'b1;
            end else if (rd_ok) begin
                unread  <= 1'b0;
            end
            ack_req <= (ack_req && !ack_take) || rd_ok;
        end
    end

    // R5
    hold_unread_chk: assert property (@(posedge clk) disable iff (rst)
        (unread && fresh) |=> $stable(rx_data));

    // R8
    ack_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_req) |-> $past(host_rd));

endmodule

// File: rtl/mon_rx_ack.sv
module mon_rx_ack
    import mon_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_stb,
    input  logic rx_ctrl,
    input  logic ack_req,
    output logic ack_take,
    output logic mr_out
);

    ack_state_e state_q;
    ack_state_e state_d;

    always_comb begin
        ack_take = frame_stb && rx_ctrl && ack_req && (state_q != ACK_GAP);
        state_d  = state_q;
        if (frame_stb) begin
            if (!rx_ctrl) begin
                state_d = ACK_OFF;
            end else begin
                unique case (state_q)
                    ACK_OFF: state_d = ack_req ? ACK_ON  : ACK_OFF;
                    ACK_ON:  state_d = ack_req ? ACK_GAP : ACK_ON;
                    ACK_GAP: state_d = ACK_ON;
                    default: state_d = ACK_OFF;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACK_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign mr_out = (state_q == ACK_ON) ? FLAG_ACTIVE : FLAG_IDLE;

    // R10
    ctrl_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !rx_ctrl) |=> (mr_out == FLAG_IDLE));

    // R7
    gap_one_frame_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ACK_GAP) && frame_stb && rx_ctrl) |=> (mr_out == FLAG_ACTIVE));

    // R2
    mr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(mr_out));

endmodule

// File: rtl/mon_rx_handshake.sv
module mon_rx_handshake
    import mon_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic              mx_in,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_ctrl,
    input  logic              host_rd,
    output logic              mr_out,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq_data,
    output logic              irq_end
);

    mx_event_t ev;
    logic      ack_req;
    logic      ack_take;

    mon_rx_mx_track u_track (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .mx_in     (mx_in),
        .ev        (ev),
        .irq_end   (irq_end)
    );

    mon_rx_store #(.DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .fresh    (ev.fresh),
        .rx_byte  (rx_byte),
        .host_rd  (host_rd),
        .ack_take (ack_take),
        .rx_data  (rx_data),
        .irq_data (irq_data),
        .ack_req  (ack_req)
    );

    mon_rx_ack u_ack (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .rx_ctrl   (rx_ctrl),
        .ack_req   (ack_req),
        .ack_take  (ack_take),
        .mr_out    (mr_out)
    );

    // R11
    irq_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_data, irq_end}));

    // R3
    data_on_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        irq_data |-> ($past(frame_stb) && ($past(mx_in) == FLAG_ACTIVE)));

    // R2
    data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(rx_data));

endmodule

// File: tb/test_mon_rx_handshake.sv
module test_mon_rx_handshake;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_stb = 1'b0;
    logic          mx_in = 1'b1;
    logic [DW-1:0] rx_byte = '0;
    logic          rx_ctrl = 1'b0;
    logic          host_rd = 1'b0;
    logic          mr_out;
    logic [DW-1:0] rx_data;
    logic          irq_data;
    logic          irq_end;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cnt_irqd = 0;
    int    cnt_irqe = 0;
    int    cnt_both = 0;
    string cur_req  = "R1";
    bit    finished = 1'b0;

    // behavioural reference state
    bit          m_mr, m_prev, m_pend, m_ack, m_msg, m_blip, m_irqd, m_irqe;
    bit [DW-1:0] m_data;

    always #5 clk = ~clk;

    mon_rx_handshake #(.DATA_W(DW)) i_mon_rx_handshake (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .mx_in(mx_in),
        .rx_byte(rx_byte), .rx_ctrl(rx_ctrl), .host_rd(host_rd),
        .mr_out(mr_out), .rx_data(rx_data), .irq_data(irq_data), .irq_end(irq_end)
    );

    always @(posedge clk) begin
        bit rd_now, latch, fresh;
        if (rst) begin
            m_mr = 1; m_prev = 1; m_pend = 0; m_ack = 0; m_msg = 0;
            m_blip = 0; m_irqd = 0; m_irqe = 0; m_data = '0;
        end else begin
            rd_now = host_rd && m_pend;
            latch  = 0;
            m_irqd = 0;
            m_irqe = 0;
            if (frame_stb) begin
                fresh = (mx_in == 0) && (m_prev == 1);
                if (fresh && !m_pend) begin
                    latch = 1; m_data = rx_byte; m_irqd = 1;
                end
                if (fresh) m_msg = 1;
                else if (mx_in && m_prev && m_msg) begin
                    m_irqe = 1; m_msg = 0;
                end
                if (!rx_ctrl) begin
                    m_mr = 1; m_blip = 0;
                end else if (m_blip) begin
                    m_mr = 0; m_blip = 0;
                end else if (m_ack) begin
                    if (m_mr) m_mr = 0;
                    else begin m_mr = 1; m_blip = 1; end
                    m_ack = 0;
                end
                m_prev = mx_in;
            end
            if (latch) m_pend = 1;
            else if (rd_now) m_pend = 0;
            if (rd_now) m_ack = 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_checks++;
            if (mr_out !== m_mr || rx_data !== m_data || irq_data !== m_irqd || irq_end !== m_irqe) begin
                n_fail++;
                $display("FAIL %s model: mr=%0b data=%h irqd=%0b irqe=%0b expected mr=%0b data=%h irqd=%0b irqe=%0b",
                         cur_req, mr_out, rx_data, irq_data, irq_end, m_mr, m_data, m_irqd, m_irqe);
            end
            if (irq_data) cnt_irqd++;
            if (irq_end)  cnt_irqe++;
            if (irq_data && irq_end) cnt_both++;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic frame(input logic mx, input logic [DW-1:0] b);
        @(negedge clk);
        frame_stb = 1'b1; mx_in = mx; rx_byte = b;
        @(negedge clk);
        frame_stb = 1'b0;
        #1;
    endtask

    task automatic rd();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        #1;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        int d0, e0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 mr", mr_out, 1);
        check("R1 data", rx_data, 0);
        check("R1 irq", irq_data | irq_end, 0);

        rx_ctrl = 1'b1;
        cur_req = "R9";
        frame(1, 8'h11); frame(1, 8'h12); frame(1, 8'h13);
        check("R9 no end while idle", cnt_irqe, 0);

        cur_req = "R3";
        frame(0, 8'hA5);
        check("R3 irq pulse", irq_data, 1);
        check("R3 data", rx_data, 8'hA5);
        gap(1);
        check("R3 pulse one cycle", irq_data, 0);

        cur_req = "R4";
        d0 = cnt_irqd;
        frame(0, 8'h5A);
        check("R4 repeat no irq", cnt_irqd, d0);
        check("R4 repeat no store", rx_data, 8'hA5);
        check("R8 no ack before read", mr_out, 1);

        cur_req = "R2";
        @(negedge clk); mx_in = 1; rx_byte = 8'hFF;
        @(negedge clk); mx_in = 0; rx_byte = 8'h00;
        @(negedge clk); #1;
        check("R2 no strobe no change", rx_data, 8'hA5);
        check("R2 mr quiet", mr_out, 1);

        cur_req = "R6";
        rd();
        check("R6 mr waits for frame", mr_out, 1);
        frame(0, 8'hA5);
        check("R6 first ack", mr_out, 0);

        cur_req = "R3";
        frame(1, 8'h3C);
        frame(0, 8'h3C);
        check("R3 second byte", rx_data, 8'h3C);

        cur_req = "R5";
        d0 = cnt_irqd;
        frame(1, 8'h77);
        frame(0, 8'h77);
        check("R5 unread kept", rx_data, 8'h3C);
        check("R5 no irq", cnt_irqd, d0);

        cur_req = "R7";
        rd();
        frame(0, 8'h77);
        check("R7 blip inactive", mr_out, 1);
        frame(0, 8'h77);
        check("R7 back active", mr_out, 0);
        frame(0, 8'h77);
        check("R7 stays active", mr_out, 0);

        cur_req = "R8";
        rd();
        frame(0, 8'h77); frame(0, 8'h77);
        check("R8 empty read ignored", mr_out, 0);

        cur_req = "R9";
        e0 = cnt_irqe;
        frame(1, 8'h00);
        check("R9 one idle frame no end", cnt_irqe, e0);
        frame(1, 8'h00);
        check("R9 end pulse", cnt_irqe, e0 + 1);
        frame(1, 8'h00); frame(1, 8'h00);
        check("R9 end once", cnt_irqe, e0 + 1);

        cur_req = "R10";
        frame(0, 8'h42);
        check("R10 new message byte", rx_data, 8'h42);
        rd();
        frame(0, 8'h42);
        check("R10 acked", mr_out, 1);
        rx_ctrl = 1'b0;
        frame(0, 8'h42);
        check("R10 forced inactive", mr_out, 1);
        frame(0, 8'h42);
        check("R10 held inactive", mr_out, 1);
        rx_ctrl = 1'b1;
        frame(1, 8'h00); frame(1, 8'h00);

        check("R11 never both", cnt_both, 0);
        gap(2);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule